// File: doc/BRIEF.md
# Dual-Bank Endpoint Buffer Controller

This block holds the packet storage for one device-side endpoint and decides, cycle by cycle, whether each storage bank belongs to the processor or to the bus packet engine. It has one or two banks, and each bank holds one packet together with its own byte count. A static direction input selects the mode. In host-to-device (OUT) mode the packet engine fills a bank and the processor drains it. In device-to-host (IN) mode the processor fills a bank and the packet engine drains it.

The processor sees a single byte-wide data port, an ownership flag, a flag that says whether the data port may be used, a transmit-ready flag and a receive flag, an enable for each of those two flags, and a sticky protocol-error flag. When the processor clears the ownership flag, the bank it holds goes to the packet engine and its side moves to the other bank. Ownership and the interrupt flags are then reloaded from that other bank's state at the same clock edge. As a result, a second bank that is already full (OUT) or already free (IN) raises its interrupt with no idle cycle in between.

Top module: `epbuf_ctrl`

## Requirements
- R1: While reset is held, own_flag, txi_flag, rxi_flag, err_flag, irq and cpu_byte_cnt are all 0, and in OUT mode (cfg_dir_in = 0) usb_bank_ready is 1.
- R2: In IN mode (cfg_dir_in = 1), when the processor-side bank becomes free, own_flag and txi_flag rise at the same clock edge. This includes the first edge after reset.
- R3: irq equals (txi_flag AND cpu_txi_en) OR (rxi_flag AND cpu_rxi_en).
- R4: In IN mode each cpu_wr_en pulse stores one byte and increments cpu_byte_cnt. When the count reaches EP_SIZE, rw_allowed drops to 0 and further writes change nothing.
- R5: In IN mode, clearing ownership while txi_flag is 0 queues the bank for the packet engine. usb_bank_ready rises, usb_byte_cnt shows the stored count, and usb_rd_en returns the bytes in write order, followed by 0 once the count is exhausted. A usb_tx_done pulse frees the bank. With two banks, own_flag and txi_flag are reloaded from the other bank at the edge of the clear.
- R6: In IN mode, a clear of ownership while txi_flag is still 1 is refused. The bank, own_flag and the count are kept, and err_flag is set. err_flag stays set until a cpu_err_clr pulse.
- R7: In OUT mode the packet engine fills the free bank with usb_wr_en. A usb_pkt_done pulse hands that bank to the processor: own_flag and rxi_flag rise together, and cpu_byte_cnt shows the packet length.
- R8: In OUT mode each cpu_rd_en pulse advances through the packet, with cpu_rd_data valid before the pulse. rw_allowed falls after the N-th read of an N-byte packet, and cpu_rd_data is 0 from then on.
- R9: With two banks in OUT mode, the packet engine can fill the second bank while the processor holds the first. Clearing ownership then switches to that bank, and own_flag and rxi_flag are 1 at the very next edge, with the new count shown.
- R10: With one bank, a released bank never comes back through a switch. own_flag stays 0 until usb_tx_done (IN) or usb_pkt_done (OUT) returns it.
- R11: A usb_pkt_done, usb_wr_en or usb_tx_done pulse while usb_bank_ready is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dir_in | input | 1 | 1 = IN (device to host), 0 = OUT; static outside reset |
| cpu_wr_en | input | 1 | Processor data-port write strobe (IN mode) |
| cpu_wr_data | input | DATA_W | Processor write byte |
| cpu_rd_en | input | 1 | Processor data-port read strobe (OUT mode) |
| cpu_rd_data | output | DATA_W | Byte at the processor read position, 0 when not allowed |
| cpu_own_clr | input | 1 | Give the held bank back to hardware |
| cpu_txi_clr | input | 1 | Clear the transmit-ready flag |
| cpu_rxi_clr | input | 1 | Clear the receive flag |
| cpu_err_clr | input | 1 | Clear the sticky error flag |
| cpu_txi_en | input | 1 | Interrupt enable for the transmit-ready flag |
| cpu_rxi_en | input | 1 | Interrupt enable for the receive flag |
| own_flag | output | 1 | Processor holds a bank |
| rw_allowed | output | 1 | Data port may be written (IN) or read (OUT) |
| txi_flag | output | 1 | Transmit-ready flag |
| rxi_flag | output | 1 | Receive flag |
| err_flag | output | 1 | Sticky ordering error |
| irq | output | 1 | Enabled-flag interrupt |
| cpu_byte_cnt | output | CNT_W | Byte count of the processor-side bank |
| usb_wr_en | input | 1 | Packet-engine write strobe (OUT mode) |
| usb_wr_data | input | DATA_W | Packet-engine write byte |
| usb_pkt_done | input | 1 | Received packet complete (OUT mode) |
| usb_rd_en | input | 1 | Packet-engine read strobe (IN mode) |
| usb_rd_data | output | DATA_W | Byte at the packet-engine read position |
| usb_tx_done | input | 1 | Transmission complete, bank freed (IN mode) |
| usb_bank_ready | output | 1 | Packet engine has a bank to fill (OUT) or send (IN) |
| usb_byte_cnt | output | CNT_W | Byte count of the packet-engine bank |

## Verification
The assertions assume that cfg_dir_in changes only while reset is held, and that the processor strobes behave as single-cycle register accesses. Under these assumptions the ownership, error and zero-fill relations hold at every edge, and the direction never changes under a live bank. The bench changes direction only inside its reset task. It drives every strobe for exactly one cycle from tasks. It deliberately issues the out-of-order ownership clear, and the packet-engine completions with no bank ready, to reach the refused and ignored paths. Random packet lengths and contents stay within 1 to EP_SIZE bytes.

// File: rtl/epbuf_pkg.sv
package epbuf_pkg;

   typedef enum logic {
      EP_DIR_OUT = 1'b0,
      EP_DIR_IN  = 1'b1
   } ep_dir_e;

   // A bank marked "ready" waits for the consumer of its direction:
   // OUT -> processor, IN -> packet engine.
   function automatic logic cpu_side_avail(input ep_dir_e dir, input logic bank_ready);
      return (dir == EP_DIR_IN) ? !bank_ready : bank_ready;
   endfunction

   function automatic logic usb_side_avail(input ep_dir_e dir, input logic bank_ready);
      return (dir == EP_DIR_IN) ? bank_ready : !bank_ready;
   endfunction

endpackage

// File: rtl/epbuf_bank.sv
module epbuf_bank #(
   parameter int DATA_W  = 8,
   parameter int EP_SIZE = 16,
   parameter int CNT_W   = $clog2(EP_SIZE + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              clr,
   input  logic [CNT_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  cnt,
   output logic              full
);

   localparam int IDX_W = $clog2(EP_SIZE);

   logic [DATA_W-1:0] mem_q [EP_SIZE];
   logic [CNT_W-1:0]  cnt_q;
   logic              push;

   assign full = (cnt_q == CNT_W'(EP_SIZE));
   assign push = wr_en && !full;
   assign cnt  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (push) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // Storage needs no reset: bytes at or past the count are masked.
   always_ff @(posedge clk) begin
      if (push && !clr) begin
         mem_q[cnt_q[IDX_W-1:0]] <= wr_data;
      end
   end

   assign rd_data = (rd_idx < cnt_q) ? mem_q[rd_idx[IDX_W-1:0]] : '0;

endmodule

// File: rtl/epbuf_flags.sv
module epbuf_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic set_tx,
   input  logic clr_tx,
   input  logic set_rx,
   input  logic clr_rx,
   input  logic set_err,
   input  logic clr_err,
   input  logic tx_en,
   input  logic rx_en,
   output logic tx_flag,
   output logic rx_flag,
   output logic err_flag,
   output logic irq
);

   logic tx_q, rx_q, err_q;

   // Hardware set wins over a software clear in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q  <= 1'b0;
         rx_q  <= 1'b0;
         err_q <= 1'b0;
      end else begin
         if (set_tx)       tx_q <= 1'b1;
         else if (clr_tx)  tx_q <= 1'b0;
         if (set_rx)       rx_q <= 1'b1;
         else if (clr_rx)  rx_q <= 1'b0;
         if (set_err)      err_q <= 1'b1;
         else if (clr_err) err_q <= 1'b0;
      end
   end

   assign tx_flag  = tx_q;
   assign rx_flag  = rx_q;
   assign err_flag = err_q;
   assign irq      = (tx_q && tx_en) || (rx_q && rx_en);

endmodule

// File: rtl/epbuf_ctrl.sv
module epbuf_ctrl
   import epbuf_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int EP_SIZE   = 16,
   parameter int NUM_BANKS = 2,
   localparam int CNT_W    = $clog2(EP_SIZE + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_dir_in,
   input  logic              cpu_wr_en,
   input  logic [DATA_W-1:0] cpu_wr_data,
   input  logic              cpu_rd_en,
   output logic [DATA_W-1:0] cpu_rd_data,
   input  logic              cpu_own_clr,
   input  logic              cpu_txi_clr,
   input  logic              cpu_rxi_clr,
   input  logic              cpu_err_clr,
   input  logic              cpu_txi_en,
   input  logic              cpu_rxi_en,
   output logic              own_flag,
   output logic              rw_allowed,
   output logic              txi_flag,
   output logic              rxi_flag,
   output logic              err_flag,
   output logic              irq,
   output logic [CNT_W-1:0]  cpu_byte_cnt,
   input  logic              usb_wr_en,
   input  logic [DATA_W-1:0] usb_wr_data,
   input  logic              usb_pkt_done,
   input  logic              usb_rd_en,
   output logic [DATA_W-1:0] usb_rd_data,
   input  logic              usb_tx_done,
   output logic              usb_bank_ready,
   output logic [CNT_W-1:0]  usb_byte_cnt
);

   localparam int SLOTS = 2;

   // ---------------- elaboration checks ----------------
   if (NUM_BANKS < 1 || NUM_BANKS > 2) begin : g_bad_banks
      $error("epbuf_ctrl: NUM_BANKS must be 1 or 2");
   end
   if (EP_SIZE < 2 || (EP_SIZE & (EP_SIZE - 1)) != 0) begin : g_bad_size
      $error("epbuf_ctrl: EP_SIZE must be a power of two of at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("epbuf_ctrl: DATA_W must be positive");
   end

   // ---------------- state ----------------
   ep_dir_e           dir;
   logic [SLOTS-1:0]  ready_q, ready_n;
   logic              cpu_sel_q, cpu_sel_n;
   logic              usb_sel_q, usb_sel_n;
   logic              own_q, own_n;
   logic [CNT_W-1:0]  cpu_ptr_q, usb_ptr_q;

   logic [DATA_W-1:0] bk_rd   [SLOTS];
   logic [CNT_W-1:0]  bk_cnt  [SLOTS];
   logic [SLOTS-1:0]  bk_full;

   logic              usb_avail;
   logic              release_ok, order_err, usb_done, set_evt;
   logic              is_in;
   logic [CNT_W-1:0]  rd_idx;

   assign dir   = ep_dir_e'(cfg_dir_in);
   assign is_in = (dir == EP_DIR_IN);

   assign usb_avail  = usb_side_avail(dir, ready_q[usb_sel_q]);
   assign release_ok = cpu_own_clr && own_q && !(is_in && txi_flag);
   assign order_err  = cpu_own_clr && own_q && is_in && txi_flag;
   assign usb_done   = usb_avail && (is_in ? usb_tx_done : usb_pkt_done);

   // ---------------- bank selection variant ----------------
   if (NUM_BANKS == 2) begin : g_pingpong
      assign cpu_sel_n = cpu_sel_q ^ release_ok;
      assign usb_sel_n = usb_sel_q ^ usb_done;
   end else begin : g_fixed
      assign cpu_sel_n = 1'b0;
      assign usb_sel_n = 1'b0;
   end

   // ---------------- next bank ownership ----------------
   always_comb begin
      ready_n = ready_q;
      if (release_ok) ready_n[cpu_sel_q] = is_in;
      if (usb_done)   ready_n[usb_sel_q] = !is_in;
   end

   // Ownership reloads from the bank selected after this edge.
   assign own_n   = cpu_side_avail(dir, ready_n[cpu_sel_n]);
   assign set_evt = own_n && (!own_q || release_ok);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q   <= '0;
         cpu_sel_q <= 1'b0;
         usb_sel_q <= 1'b0;
         own_q     <= 1'b0;
         cpu_ptr_q <= '0;
         usb_ptr_q <= '0;
      end else begin
         ready_q   <= ready_n;
         cpu_sel_q <= cpu_sel_n;
         usb_sel_q <= usb_sel_n;
         own_q     <= own_n;
         if (release_ok) begin
            cpu_ptr_q <= '0;
         end else if (!is_in && cpu_rd_en && rw_allowed) begin
            cpu_ptr_q <= cpu_ptr_q + 1'b1;
         end
         if (usb_done) begin
            usb_ptr_q <= '0;
         end else if (is_in && usb_rd_en && usb_avail && (usb_ptr_q < bk_cnt[usb_sel_q])) begin
            usb_ptr_q <= usb_ptr_q + 1'b1;
         end
      end
   end

   // ---------------- banks ----------------
   assign rd_idx = is_in ? usb_ptr_q : cpu_ptr_q;

   for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
      logic wr_i, clr_i;
      logic [DATA_W-1:0] wd_i;

      assign wr_i  = is_in ? (cpu_wr_en && own_q && (cpu_sel_q == 1'(i)))
                           : (usb_wr_en && usb_avail && (usb_sel_q == 1'(i)));
      assign wd_i  = is_in ? cpu_wr_data : usb_wr_data;
      assign clr_i = is_in ? (usb_done && (usb_sel_q == 1'(i)))
                           : (release_ok && (cpu_sel_q == 1'(i)));

      epbuf_bank #(
         .DATA_W  (DATA_W),
         .EP_SIZE (EP_SIZE),
         .CNT_W   (CNT_W)
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_i),
         .wr_data (wd_i),
         .clr     (clr_i),
         .rd_idx  (rd_idx),
         .rd_data (bk_rd[i]),
         .cnt     (bk_cnt[i]),
         .full    (bk_full[i])
      );
   end

   if (NUM_BANKS == 1) begin : g_pad
      assign bk_rd[1]   = '0;
      assign bk_cnt[1]  = '0;
      assign bk_full[1] = 1'b0;
   end

   // ---------------- flags ----------------
   epbuf_flags u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_tx   (set_evt && is_in),
      .clr_tx   (cpu_txi_clr),
      .set_rx   (set_evt && !is_in),
      .clr_rx   (cpu_rxi_clr),
      .set_err  (order_err),
      .clr_err  (cpu_err_clr),
      .tx_en    (cpu_txi_en),
      .rx_en    (cpu_rxi_en),
      .tx_flag  (txi_flag),
      .rx_flag  (rxi_flag),
      .err_flag (err_flag),
      .irq      (irq)
   );

   // ---------------- outputs ----------------
   assign own_flag       = own_q;
   assign rw_allowed     = own_q && (is_in ? !bk_full[cpu_sel_q]
                                           : (cpu_ptr_q < bk_cnt[cpu_sel_q]));
   assign cpu_rd_data    = (!is_in && own_q) ? bk_rd[cpu_sel_q] : '0;
   assign cpu_byte_cnt   = bk_cnt[cpu_sel_q];
   assign usb_rd_data    = (is_in && usb_avail) ? bk_rd[usb_sel_q] : '0;
   assign usb_bank_ready = usb_avail;
   assign usb_byte_cnt   = bk_cnt[usb_sel_q];

endmodule

// File: rtl/epbuf_ctrl_chk.sv
module epbuf_ctrl_chk #(
   parameter int DATA_W    = 8,
   parameter int EP_SIZE   = 16,
   parameter int NUM_BANKS = 2,
   localparam int CNT_W    = $clog2(EP_SIZE + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_dir_in,
   input logic              cpu_own_clr,
   input logic              cpu_err_clr,
   input logic              own_flag,
   input logic              rw_allowed,
   input logic              txi_flag,
   input logic              rxi_flag,
   input logic              err_flag,
   input logic [CNT_W-1:0]  cpu_byte_cnt,
   input logic [DATA_W-1:0] cpu_rd_data
);

   AST_TX_WITH_OWN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(txi_flag) |-> own_flag); // R2

   AST_WR_STOP_AT_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_dir_in && own_flag && cpu_byte_cnt == CNT_W'(EP_SIZE)) |-> !rw_allowed); // R4

   AST_ERR_HOLDS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_dir_in && cpu_own_clr && own_flag && txi_flag) |=> (own_flag && err_flag)); // R6

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag && !cpu_err_clr) |=> err_flag); // R6

   AST_RX_WITH_OWN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rxi_flag) |-> own_flag); // R7

   AST_RD_PAST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_dir_in && !rw_allowed) |-> (cpu_rd_data == '0)); // R8

   if (NUM_BANKS == 1) begin : g_single
      AST_SINGLE_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
         (cpu_own_clr && own_flag && !(cfg_dir_in && txi_flag)) |=> !own_flag); // R10
   end

endmodule

bind epbuf_ctrl epbuf_ctrl_chk #(
   .DATA_W    (DATA_W),
   .EP_SIZE   (EP_SIZE),
   .NUM_BANKS (NUM_BANKS)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_dir_in   (cfg_dir_in),
   .cpu_own_clr  (cpu_own_clr),
   .cpu_err_clr  (cpu_err_clr),
   .own_flag     (own_flag),
   .rw_allowed   (rw_allowed),
   .txi_flag     (txi_flag),
   .rxi_flag     (rxi_flag),
   .err_flag     (err_flag),
   .cpu_byte_cnt (cpu_byte_cnt),
   .cpu_rd_data  (cpu_rd_data)
);

// File: tb/epbuf_ctrl_bench.sv
module epbuf_ctrl_bench;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 8;
   localparam int EP = 16;
   localparam int CW = $clog2(EP + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_dir_in = 1'b0;
   logic cpu_wr_en = 0, cpu_rd_en = 0, cpu_own_clr = 0;
   logic cpu_txi_clr = 0, cpu_rxi_clr = 0, cpu_err_clr = 0;
   logic cpu_txi_en = 0, cpu_rxi_en = 0;
   logic [DW-1:0] cpu_wr_data = '0, usb_wr_data = '0;
   logic usb_wr_en = 0, usb_pkt_done = 0, usb_rd_en = 0, usb_tx_done = 0;

   logic [DW-1:0] cpu_rd_data, usb_rd_data;
   logic own_flag, rw_allowed, txi_flag, rxi_flag, err_flag, irq, usb_bank_ready;
   logic [CW-1:0] cpu_byte_cnt, usb_byte_cnt;

   logic [DW-1:0] s_cpu_rd_data, s_usb_rd_data;
   logic s_own, s_rw, s_txi, s_rxi, s_err, s_irq, s_usb_rdy;
   logic [CW-1:0] s_cpu_cnt, s_usb_cnt;

   int nvec = 0;
   int nfail = 0;
   bit done = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   epbuf_ctrl #(.DATA_W(DW), .EP_SIZE(EP), .NUM_BANKS(2)) u_epbuf_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_dir_in(cfg_dir_in),
      .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data), .cpu_rd_en(cpu_rd_en),
      .cpu_rd_data(cpu_rd_data), .cpu_own_clr(cpu_own_clr), .cpu_txi_clr(cpu_txi_clr),
      .cpu_rxi_clr(cpu_rxi_clr), .cpu_err_clr(cpu_err_clr), .cpu_txi_en(cpu_txi_en),
      .cpu_rxi_en(cpu_rxi_en), .own_flag(own_flag), .rw_allowed(rw_allowed),
      .txi_flag(txi_flag), .rxi_flag(rxi_flag), .err_flag(err_flag), .irq(irq),
      .cpu_byte_cnt(cpu_byte_cnt), .usb_wr_en(usb_wr_en), .usb_wr_data(usb_wr_data),
      .usb_pkt_done(usb_pkt_done), .usb_rd_en(usb_rd_en), .usb_rd_data(usb_rd_data),
      .usb_tx_done(usb_tx_done), .usb_bank_ready(usb_bank_ready), .usb_byte_cnt(usb_byte_cnt)
   );

   epbuf_ctrl #(.DATA_W(DW), .EP_SIZE(EP), .NUM_BANKS(1)) u_epbuf_ctrl_single (
      .clk(clk), .rst_n(rst_n), .cfg_dir_in(cfg_dir_in),
      .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data), .cpu_rd_en(cpu_rd_en),
      .cpu_rd_data(s_cpu_rd_data), .cpu_own_clr(cpu_own_clr), .cpu_txi_clr(cpu_txi_clr),
      .cpu_rxi_clr(cpu_rxi_clr), .cpu_err_clr(cpu_err_clr), .cpu_txi_en(cpu_txi_en),
      .cpu_rxi_en(cpu_rxi_en), .own_flag(s_own), .rw_allowed(s_rw),
      .txi_flag(s_txi), .rxi_flag(s_rxi), .err_flag(s_err), .irq(s_irq),
      .cpu_byte_cnt(s_cpu_cnt), .usb_wr_en(usb_wr_en), .usb_wr_data(usb_wr_data),
      .usb_pkt_done(usb_pkt_done), .usb_rd_en(usb_rd_en), .usb_rd_data(s_usb_rd_data),
      .usb_tx_done(usb_tx_done), .usb_bank_ready(s_usb_rdy), .usb_byte_cnt(s_usb_cnt)
   );

   // ---------------- helpers ----------------
   function automatic logic [DW-1:0] pat(input logic [DW-1:0] base, input int i);
      return base + DW'(i * 29);
   endfunction

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic dir);
      rst_n = 1'b0;
      cfg_dir_in = dir;
      cpu_txi_en = 0;
      cpu_rxi_en = 0;
      step(); step();
      chk("R1 own", own_flag, 0);
      chk("R1 txi", txi_flag, 0);
      chk("R1 rxi", rxi_flag, 0);
      chk("R1 err", err_flag, 0);
      chk("R1 irq", irq, 0);
      chk("R1 cnt", cpu_byte_cnt, 0);
      if (!dir) chk("R1 usb ready", usb_bank_ready, 1);
      rst_n = 1'b1;
      step();
   endtask

   task automatic cpu_write(input logic [DW-1:0] b);
      cpu_wr_en = 1; cpu_wr_data = b; step(); cpu_wr_en = 0;
   endtask

   task automatic cpu_read(output logic [DW-1:0] b);
      b = cpu_rd_data; cpu_rd_en = 1; step(); cpu_rd_en = 0;
   endtask

   task automatic usb_write(input logic [DW-1:0] b);
      usb_wr_en = 1; usb_wr_data = b; step(); usb_wr_en = 0;
   endtask

   task automatic usb_read(output logic [DW-1:0] b);
      b = usb_rd_data; usb_rd_en = 1; step(); usb_rd_en = 0;
   endtask

   task automatic pkt_done();  usb_pkt_done = 1; step(); usb_pkt_done = 0; endtask
   task automatic tx_done();   usb_tx_done = 1;  step(); usb_tx_done = 0;  endtask
   task automatic own_clr();   cpu_own_clr = 1;  step(); cpu_own_clr = 0;  endtask
   task automatic txi_clr();   cpu_txi_clr = 1;  step(); cpu_txi_clr = 0;  endtask
   task automatic rxi_clr();   cpu_rxi_clr = 1;  step(); cpu_rxi_clr = 0;  endtask
   task automatic err_clr();   cpu_err_clr = 1;  step(); cpu_err_clr = 0;  endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nvec++;
         nfail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      logic [DW-1:0] b;
      logic [DW-1:0] base;
      int len;
      void'($urandom(32'h1A2B3C4D));

      // ===== IN direction, two banks =====
      do_reset(1'b1);
      chk("R2 own after reset", own_flag, 1);
      chk("R2 txi with own", txi_flag, 1);
      chk("R4 rw at empty", rw_allowed, 1);
      chk("R3 irq masked", irq, 0);
      cpu_txi_en = 1; #1;
      chk("R3 irq enabled", irq, 1);
      cpu_txi_en = 0;
      for (int i = 0; i < EP; i++) cpu_write(pat(8'h40, i));
      chk("R4 count full", cpu_byte_cnt, EP);
      chk("R4 rw low at size", rw_allowed, 0);
      cpu_write(8'hAA);
      chk("R4 extra write ignored", cpu_byte_cnt, EP);
      own_clr();
      chk("R6 err set", err_flag, 1);
      chk("R6 bank kept", own_flag, 1);
      chk("R6 count kept", cpu_byte_cnt, EP);
      chk("R6 nothing queued", usb_bank_ready, 0);
      step();
      chk("R6 err sticky", err_flag, 1);
      err_clr();
      chk("R6 err cleared", err_flag, 0);
      txi_clr();
      chk("R2 txi cleared", txi_flag, 0);
      own_clr();
      chk("R5 own reloaded", own_flag, 1);
      chk("R5 txi reloaded", txi_flag, 1);
      chk("R5 new bank count", cpu_byte_cnt, 0);
      chk("R5 queued", usb_bank_ready, 1);
      chk("R5 usb count", usb_byte_cnt, EP);
      for (int i = 0; i < 3; i++) cpu_write(pat(8'h90, i));
      txi_clr();
      own_clr();
      chk("R5 both queued own", own_flag, 0);
      chk("R5 both queued txi", txi_flag, 0);
      for (int i = 0; i < EP; i++) begin
         usb_read(b);
         chk("R5 drain bank0", b, pat(8'h40, i));
      end
      chk("R5 read past count", usb_rd_data, 0);
      tx_done();
      chk("R5 freed bank own", own_flag, 1);
      chk("R2 freed bank txi", txi_flag, 1);
      chk("R5 freed count", cpu_byte_cnt, 0);
      chk("R5 next usb count", usb_byte_cnt, 3);
      for (int i = 0; i < 3; i++) begin
         usb_read(b);
         chk("R5 drain bank1", b, pat(8'h90, i));
      end
      tx_done();
      chk("R5 all free", usb_bank_ready, 0);
      tx_done();
      chk("R11 stray tx_done ready", usb_bank_ready, 0);
      chk("R11 stray tx_done own", own_flag, 1);
      chk("R11 stray tx_done count", cpu_byte_cnt, 0);

      // ===== OUT direction, two banks =====
      do_reset(1'b0);
      chk("R7 idle own", own_flag, 0);
      for (int i = 0; i < 5; i++) usb_write(pat(8'h11, i));
      pkt_done();
      chk("R7 own on packet", own_flag, 1);
      chk("R7 rxi on packet", rxi_flag, 1);
      chk("R7 length", cpu_byte_cnt, 5);
      chk("R3 rx irq masked", irq, 0);
      cpu_rxi_en = 1; #1;
      chk("R3 rx irq enabled", irq, 1);
      cpu_rxi_en = 0;
      chk("R9 second bank free", usb_bank_ready, 1);
      for (int i = 0; i < 3; i++) usb_write(pat(8'h77, i));
      pkt_done();
      chk("R9 both full", usb_bank_ready, 0);
      usb_write(8'hEE);
      pkt_done();
      chk("R11 stray pkt own", own_flag, 1);
      chk("R11 stray pkt count", cpu_byte_cnt, 5);
      for (int i = 0; i < 5; i++) begin
         chk("R8 rw before read", rw_allowed, 1);
         cpu_read(b);
         chk("R8 read data", b, pat(8'h11, i));
      end
      chk("R8 rw after N reads", rw_allowed, 0);
      chk("R8 zero past end", cpu_rd_data, 0);
      cpu_read(b);
      chk("R8 zero read", b, 0);
      rxi_clr();
      chk("R7 rxi cleared", rxi_flag, 0);
      own_clr();
      chk("R9 own at once", own_flag, 1);
      chk("R9 rxi at once", rxi_flag, 1);
      chk("R9 new length", cpu_byte_cnt, 3);
      chk("R9 bank0 free again", usb_bank_ready, 1);
      for (int i = 0; i < 3; i++) begin
         cpu_read(b);
         chk("R9 bank1 data", b, pat(8'h77, i));
      end
      rxi_clr();
      own_clr();
      chk("R9 no more packets", own_flag, 0);
      chk("R9 no error in OUT", err_flag, 0);

      // ===== single bank =====
      do_reset(1'b0);
      chk("R1 single usb ready", s_usb_rdy, 1);
      usb_write(8'h21); usb_write(8'h22);
      pkt_done();
      chk("R10 single own", s_own, 1);
      chk("R10 single busy", s_usb_rdy, 0);
      rxi_clr();
      own_clr();
      chk("R10 released", s_own, 0);
      step(); step(); step();
      chk("R10 stays released", s_own, 0);
      chk("R10 back to usb", s_usb_rdy, 1);
      usb_write(8'h5C);
      pkt_done();
      chk("R10 returned by packet", s_own, 1);
      chk("R10 returned count", s_cpu_cnt, 1);
      chk("R10 returned data", s_cpu_rd_data, 8'h5C);

      do_reset(1'b1);
      chk("R10 single IN own", s_own, 1);
      chk("R10 single IN txi", s_txi, 1);
      txi_clr();
      cpu_write(8'h01); cpu_write(8'h02);
      own_clr();
      chk("R10 IN released", s_own, 0);
      step(); step(); step();
      chk("R10 IN stays released", s_own, 0);
      chk("R10 IN queued", s_usb_rdy, 1);
      chk("R10 IN usb count", s_usb_cnt, 2);
      tx_done();
      chk("R10 IN returned own", s_own, 1);
      chk("R10 IN returned txi", s_txi, 1);
      chk("R10 IN count cleared", s_cpu_cnt, 0);

      // ===== random OUT packets =====
      do_reset(1'b0);
      for (int k = 0; k < 24; k++) begin
         len  = 1 + int'($urandom % EP);
         base = DW'($urandom);
         chk("R11 engine has bank", usb_bank_ready, 1);
         for (int i = 0; i < len; i++) usb_write(pat(base, i));
         pkt_done();
         chk("R7 random own", own_flag, 1);
         chk("R7 random length", cpu_byte_cnt, len);
         for (int i = 0; i < len; i++) begin
            cpu_read(b);
            chk("R8 random data", b, pat(base, i));
         end
         chk("R8 random rw end", rw_allowed, 0);
         rxi_clr();
         own_clr();
         chk("R9 random release", own_flag, 0);
      end

      // ===== random IN packets =====
      do_reset(1'b1);
      for (int k = 0; k < 24; k++) begin
         len  = 1 + int'($urandom % EP);
         base = DW'($urandom);
         chk("R2 random own", own_flag, 1);
         for (int i = 0; i < len; i++) cpu_write(pat(base, i));
         chk("R4 random count", cpu_byte_cnt, len);
         txi_clr();
         own_clr();
         chk("R5 random reload", own_flag, 1);
         chk("R5 random usb count", usb_byte_cnt, len);
         for (int i = 0; i < len; i++) begin
            usb_read(b);
            chk("R5 random drain", b, pat(base, i));
         end
         tx_done();
         chk("R5 random freed", usb_bank_ready, 0);
      end
      chk("R6 no error in clean run", err_flag, 0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

endmodule